// File: doc/BRIEF.md
# Converter Power-Up Initialization Sequencer

This block runs the power-down, reset and start-up sequence for the digital side of an audio converter with one ADC path and one DAC path. It runs on a free-running system clock. The asynchronous power-down pin, the master clock and the frame clock are each brought into that domain through a two-flop synchronizer. The active-low pin puts both paths into power-down and raises the reset for the digital filters and the control registers. Two register bits, one per path, power down a single path without touching any register.

Each path sequencer is a four-state machine:

- `PS_OFF` is the powered-down state.
- `OFF->ARM` is taken once the pin is high, the path bit is set and the master clock is seen.
- `PS_ARM` waits for a frame-clock rising edge.
- `ARM->INIT` is taken on that edge.
- `PS_INIT` counts frame periods. The path's data is forced to zero (ADC) or to the idle level (DAC) during this state.
- `INIT->RUN` is taken when the count ends.
- `PS_RUN` marks the path ready.
- `any->OFF` is taken as soon as the pin, the path bit or the clock-presence flag drops.

A master-clock monitor has two states, `MS_LOST` and `MS_OK`:

- `LOST->OK` is taken on any synchronized clock edge.
- `OK->LOST` is taken after a timeout with no edge.

A mute-hint generator has three states, `HS_IDLE`, `HS_COUNT` and `HS_DONE`:

- `IDLE->COUNT` is taken on the pin's rising edge.
- `COUNT->DONE` is taken after the hint delay in frames.
- `any->IDLE` is taken on the pin's falling edge.

The generator pulses its output on each pin edge and again at the end of the delay, so that system software can mute externally around the points where clicks occur.

Top module: `conv_pwr_seq`

## Requirements
- R1: While the synchronized power-down pin is low, `filt_rst` is 1, both paths are powered down, and `adc_ready` and `dac_ready` are 0. The outputs reach this state within 3 system clock cycles of the pin falling.
- R2: While the ADC path is powered down, `adc_sdto_en` is 0, which means the serial ADC data line is driven low. `adc_zero` is 1 at the same time.
- R3: A path leaves power-down only after the master clock has been detected. It starts on the first frame-clock rising edge after that. With no master clock the path stays powered down.
- R4: The ADC path becomes ready on the 522nd frame-clock rising edge after its start edge. Until then `adc_sdto_en` is 1 and `adc_zero` is 1.
- R5: The DAC path becomes ready on the 516th frame-clock rising edge after its start edge. Until then `dac_idle` is 1 and `dac_ready` is 0.
- R6: Clearing `adc_pwr` powers down only the ADC path. `dac_ready` is unchanged and `filt_rst` stays 0.
- R7: Clearing `dac_pwr` powers down only the DAC path. `adc_ready` is unchanged and `filt_rst` stays 0.
- R8: `mute_hint` gives a one-cycle pulse on each edge of the power-down pin. It gives another one-cycle pulse on the 512th frame-clock rising edge after the pin rises.
- R9: If no master-clock edge is seen for `MCLK_TIMEOUT` system cycles, both paths return to power-down. When the clock returns, each path runs a complete new initialization window.
- R10: If a path's power bit is cleared and set again during initialization, that path's frame count restarts from zero at its next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| sys_rst_n | input | 1 | Active-low system reset for the sequencer itself |
| pdn_n | input | 1 | Asynchronous active-low power-down pin |
| mclk | input | 1 | Master clock, monitored for presence |
| lrck | input | 1 | Frame clock |
| adc_pwr | input | 1 | Register bit: 1 powers the ADC path |
| dac_pwr | input | 1 | Register bit: 1 powers the DAC path |
| filt_rst | output | 1 | Reset for the digital filters and the control registers |
| adc_ready | output | 1 | ADC output data valid |
| adc_zero | output | 1 | Force ADC output data to zero |
| adc_sdto_en | output | 1 | Gate on the serial ADC data line (0 drives the line low) |
| dac_ready | output | 1 | DAC path initialized |
| dac_idle | output | 1 | Hold the DAC output at its idle level |
| mute_hint | output | 1 | One-cycle hint to mute externally |

## Verification
The main function is tried with four patterns:

- **A clean pin release with both clocks running.** The ready flags are sampled one frame either side of frames 516 and 522. This separates an exact count from an off-by-one count, and separates the two path lengths from each other.
- **A pin release with the master clock stopped.** This tells clock gating apart from pin gating.
- **A single power bit cleared, then set again halfway through a window.** This tells a counter that restarts apart from one that resumes. It also shows whether the other path stays isolated.
- **The master clock stopped and then resumed.** This shows whether the timeout drops both paths and whether the window runs again in full.

Hint pulses are counted frame by frame to separate the pin-edge pulses from the delayed pulse at frame 512.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_ARM  = 2'd1,
        PS_INIT = 2'd2,
        PS_RUN  = 2'd3
    } path_state_t;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_COUNT = 2'd1,
        HS_DONE  = 2'd2
    } hint_state_t;

    typedef enum logic {
        MS_LOST = 1'b0,
        MS_OK   = 1'b1
    } mclk_state_t;

    localparam int unsigned NUM_PATHS = 2;
    localparam int unsigned PATH_ADC  = 0;
    localparam int unsigned PATH_DAC  = 1;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= d_async;
            for (int i = 1; i < int'(STAGES); i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign d_sync = pipe[STAGES-1];

endmodule

// File: rtl/pwrseq_mclk_mon.sv
module pwrseq_mclk_mon
    import pwrseq_pkg::*;
#(
    parameter int unsigned TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_s,
    output logic mclk_ok
);

    localparam int unsigned CW = $clog2(TIMEOUT + 1);

    mclk_state_t   state, nxt;
    logic          prev;
    logic          edge_seen;
    logic [CW-1:0] idle_cnt;

    assign edge_seen = mclk_s ^ prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= MS_LOST;
            prev     <= 1'b0;
            idle_cnt <= '0;
        end else begin
            state <= nxt;
            prev  <= mclk_s;
            if (edge_seen) begin
                idle_cnt <= '0;
            end else if (idle_cnt != CW'(TIMEOUT)) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            MS_LOST: if (edge_seen) nxt = MS_OK;
            MS_OK:   if (!edge_seen && idle_cnt == CW'(TIMEOUT - 1)) nxt = MS_LOST;
            default: nxt = MS_LOST;
        endcase
    end

    // Outputs
    always_comb begin
        mclk_ok = (state == MS_OK);
    end

    // R9: while the clock is considered present, the gap counter is below the timeout
    assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_OK) |-> (idle_cnt < CW'(TIMEOUT)));

endmodule

// File: rtl/pwrseq_path.sv
module pwrseq_path
    import pwrseq_pkg::*;
#(
    parameter int unsigned INIT_LEN = 522
) (
    input  logic clk,
    input  logic rst_n,
    input  logic global_on,
    input  logic pwr_bit,
    input  logic mclk_ok,
    input  logic frame_tick,
    output logic active,
    output logic ready
);

    localparam int unsigned CW = $clog2(INIT_LEN + 1);

    path_state_t   state, nxt;
    logic [CW-1:0] frame_cnt;
    logic          enable;
    logic          last_frame;

    assign enable     = global_on & pwr_bit & mclk_ok;
    assign last_frame = (frame_cnt == CW'(INIT_LEN - 1));

    // State register and frame counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= PS_OFF;
            frame_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == PS_INIT && nxt == PS_INIT && frame_tick) begin
                frame_cnt <= frame_cnt + 1'b1;
            end else if (state != PS_INIT) begin
                frame_cnt <= '0;
            end
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF:  nxt = PS_ARM;
                PS_ARM:  if (frame_tick) nxt = PS_INIT;
                PS_INIT: if (frame_tick && last_frame) nxt = PS_RUN;
                PS_RUN:  nxt = PS_RUN;
                default: nxt = PS_OFF;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            ready  <= 1'b0;
        end else begin
            active <= (nxt == PS_INIT) || (nxt == PS_RUN);
            ready  <= (nxt == PS_RUN);
        end
    end

    // R6 / R7: losing any enable condition powers the path down on the next cycle
    assert_off_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!active && !ready));

    // R3: a path becomes active only in the cycle after a frame edge
    assert_start_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(frame_tick));

    // R4 / R5: readiness is granted only on a frame edge
    assert_ready_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(frame_tick));

    // R10: the window counter never passes the window length
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_INIT) |-> (frame_cnt < CW'(INIT_LEN)));

endmodule

// File: rtl/pwrseq_hint.sv
module pwrseq_hint
    import pwrseq_pkg::*;
#(
    parameter int unsigned DELAY = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_on,
    input  logic frame_tick,
    output logic hint
);

    localparam int unsigned CW = $clog2(DELAY + 1);

    hint_state_t   state, nxt;
    logic          prev_on;
    logic          pin_rise;
    logic          pin_fall;
    logic          timer_hit;
    logic [CW-1:0] frame_cnt;

    assign pin_rise  = pin_on & ~prev_on;
    assign pin_fall  = ~pin_on & prev_on;
    assign timer_hit = (state == HS_COUNT) && frame_tick && !pin_fall &&
                       (frame_cnt == CW'(DELAY - 1));

    // State register and frame counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= HS_IDLE;
            prev_on   <= 1'b0;
            frame_cnt <= '0;
        end else begin
            state   <= nxt;
            prev_on <= pin_on;
            if (state == HS_COUNT && nxt == HS_COUNT && frame_tick) begin
                frame_cnt <= frame_cnt + 1'b1;
            end else if (state != HS_COUNT) begin
                frame_cnt <= '0;
            end
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            HS_IDLE:  if (pin_rise) nxt = HS_COUNT;
            HS_COUNT: begin
                if (pin_fall)       nxt = HS_IDLE;
                else if (timer_hit) nxt = HS_DONE;
            end
            HS_DONE:  if (pin_fall) nxt = HS_IDLE;
            default:  nxt = HS_IDLE;
        endcase
    end

    // Registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hint <= 1'b0;
        end else begin
            hint <= pin_rise | pin_fall | timer_hit;
        end
    end

    // R8: the delay counter stays inside its window
    assert_hint_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_COUNT) |-> (frame_cnt < CW'(DELAY)));

endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned ADC_INIT_FRAMES = 522,
    parameter int unsigned DAC_INIT_FRAMES = 516,
    parameter int unsigned HINT_FRAMES     = 512,
    parameter int unsigned MCLK_TIMEOUT    = 32,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic pdn_n,
    input  logic mclk,
    input  logic lrck,
    input  logic adc_pwr,
    input  logic dac_pwr,
    output logic filt_rst,
    output logic adc_ready,
    output logic adc_zero,
    output logic adc_sdto_en,
    output logic dac_ready,
    output logic dac_idle,
    output logic mute_hint
);

    localparam int unsigned SYNC_W = 3;
    localparam int unsigned INIT_TAB [NUM_PATHS] = '{ADC_INIT_FRAMES, DAC_INIT_FRAMES};

    logic [SYNC_W-1:0]    raw_in;
    logic [SYNC_W-1:0]    sync_out;
    logic                 pdn_s;
    logic                 lrck_s;
    logic                 mclk_s;
    logic                 lrck_prev;
    logic                 frame_tick;
    logic                 mclk_ok;
    logic [NUM_PATHS-1:0] pwr_bits;
    logic [NUM_PATHS-1:0] path_active;
    logic [NUM_PATHS-1:0] path_ready;

    assign raw_in = {mclk, lrck, pdn_n};

    pwrseq_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .d_async (raw_in),
        .d_sync  (sync_out)
    );

    assign pdn_s  = sync_out[0];
    assign lrck_s = sync_out[1];
    assign mclk_s = sync_out[2];

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            lrck_prev <= 1'b0;
        end else begin
            lrck_prev <= lrck_s;
        end
    end

    assign frame_tick = lrck_s & ~lrck_prev;

    pwrseq_mclk_mon #(
        .TIMEOUT (MCLK_TIMEOUT)
    ) u_mclk_mon (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .mclk_s  (mclk_s),
        .mclk_ok (mclk_ok)
    );

    assign pwr_bits[PATH_ADC] = adc_pwr;
    assign pwr_bits[PATH_DAC] = dac_pwr;

    for (genvar g = 0; g < int'(NUM_PATHS); g++) begin : g_path
        pwrseq_path #(
            .INIT_LEN (INIT_TAB[g])
        ) u_path (
            .clk        (sys_clk),
            .rst_n      (sys_rst_n),
            .global_on  (pdn_s),
            .pwr_bit    (pwr_bits[g]),
            .mclk_ok    (mclk_ok),
            .frame_tick (frame_tick),
            .active     (path_active[g]),
            .ready      (path_ready[g])
        );
    end

    pwrseq_hint #(
        .DELAY (HINT_FRAMES)
    ) u_hint (
        .clk        (sys_clk),
        .rst_n      (sys_rst_n),
        .pin_on     (pdn_s),
        .frame_tick (frame_tick),
        .hint       (mute_hint)
    );

    assign filt_rst    = ~pdn_s;
    assign adc_ready   = path_ready[PATH_ADC];
    assign adc_zero    = ~path_ready[PATH_ADC];
    assign adc_sdto_en = path_active[PATH_ADC];
    assign dac_ready   = path_ready[PATH_DAC];
    assign dac_idle    = ~path_ready[PATH_DAC];

    // R1: pin power-down drops both paths on the following cycle
    assert_pin_down_R1: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !pdn_s |=> (!path_active[PATH_ADC] && !path_active[PATH_DAC]));

    // R2: a gated ADC data line never carries valid data
    assert_sdto_low_R2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !adc_sdto_en |-> (adc_zero && !adc_ready));

    // R9: missing master clock takes both paths down
    assert_clock_loss_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !mclk_ok |=> (!adc_sdto_en && !dac_ready));

endmodule

// File: tb/conv_pwr_seq_bench.sv
module conv_pwr_seq_bench;

    logic sys_clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic pdn_n = 1'b0;
    logic mclk = 1'b0;
    logic lrck = 1'b0;
    logic adc_pwr = 1'b1;
    logic dac_pwr = 1'b1;
    logic mclk_on = 1'b0;
    logic filt_rst, adc_ready, adc_zero, adc_sdto_en, dac_ready, dac_idle, mute_hint;

    int nchk = 0;
    int nerr = 0;
    int fcnt = 0;
    int hint_n = 0;

    conv_pwr_seq u_conv_pwr_seq (
        .sys_clk     (sys_clk),
        .sys_rst_n   (sys_rst_n),
        .pdn_n       (pdn_n),
        .mclk        (mclk),
        .lrck        (lrck),
        .adc_pwr     (adc_pwr),
        .dac_pwr     (dac_pwr),
        .filt_rst    (filt_rst),
        .adc_ready   (adc_ready),
        .adc_zero    (adc_zero),
        .adc_sdto_en (adc_sdto_en),
        .dac_ready   (dac_ready),
        .dac_idle    (dac_idle),
        .mute_hint   (mute_hint)
    );

    always #4 sys_clk = ~sys_clk;

    initial begin
        #3;
        forever begin
            #64 lrck = ~lrck;
        end
    end

    initial begin
        #5;
        forever begin
            #12;
            if (mclk_on) mclk = ~mclk;
        end
    end

    always @(posedge lrck) fcnt = fcnt + 1;
    always @(negedge sys_clk) if (mute_hint) hint_n = hint_n + 1;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chki(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic at_frame(input int n);
        while (fcnt < n) @(fcnt);
        #40;
    endtask

    task automatic test_reset();
        repeat (4) @(posedge sys_clk);
        #2 sys_rst_n = 1'b1;
        repeat (4) @(negedge sys_clk);
        chk("R1", "filt_rst in reset", filt_rst, 1'b1);
        chk("R1", "adc_ready in reset", adc_ready, 1'b0);
        chk("R1", "dac_ready in reset", dac_ready, 1'b0);
        chk("R2", "sdto gate in reset", adc_sdto_en, 1'b0);
        chk("R2", "adc_zero in reset", adc_zero, 1'b1);
        chk("R5", "dac_idle in reset", dac_idle, 1'b1);
    endtask

    task automatic test_no_mclk();
        int f;
        @(posedge lrck); #10;
        pdn_n = 1'b1;
        f = fcnt;
        at_frame(f + 20);
        chk("R3", "no mclk keeps ADC down", adc_sdto_en, 1'b0);
        chk("R3", "no mclk keeps DAC down", dac_ready, 1'b0);
        pdn_n = 1'b0;
        mclk_on = 1'b1;
        at_frame(fcnt + 3);
    endtask

    task automatic test_startup();
        int f0, hb;
        @(posedge lrck); #10;
        hb = hint_n;
        pdn_n = 1'b1;
        f0 = fcnt;
        #40;
        chki("R8", "hint on pin rise", hint_n, hb + 1);
        chk("R1", "filt_rst released", filt_rst, 1'b0);
        chk("R3", "waits for frame edge", adc_sdto_en, 1'b0);
        at_frame(f0 + 1);
        chk("R4", "ADC active in init", adc_sdto_en, 1'b1);
        chk("R4", "ADC zero in init", adc_zero, 1'b1);
        at_frame(f0 + 511);
        chki("R8", "no early delayed hint", hint_n, hb + 1);
        at_frame(f0 + 512);
        chki("R8", "delayed hint at 512", hint_n, hb + 2);
        at_frame(f0 + 516);
        chk("R5", "DAC not ready at 515", dac_ready, 1'b0);
        chk("R5", "DAC idle at 515", dac_idle, 1'b1);
        at_frame(f0 + 517);
        chk("R5", "DAC ready at 516", dac_ready, 1'b1);
        at_frame(f0 + 522);
        chk("R4", "ADC not ready at 521", adc_ready, 1'b0);
        at_frame(f0 + 523);
        chk("R4", "ADC ready at 522", adc_ready, 1'b1);
        chk("R4", "ADC zero released", adc_zero, 1'b0);
        chki("R8", "no extra hints", hint_n, hb + 2);
    endtask

    task automatic test_adc_bit_restart();
        int g, h;
        at_frame(fcnt + 1);
        adc_pwr = 1'b0;
        #24;
        chk("R6", "ADC gated low", adc_sdto_en, 1'b0);
        chk("R6", "ADC not ready", adc_ready, 1'b0);
        chk("R6", "DAC unaffected", dac_ready, 1'b1);
        chk("R6", "no register reset", filt_rst, 1'b0);
        @(posedge lrck); #10;
        adc_pwr = 1'b1;
        g = fcnt;
        at_frame(g + 300);
        chk("R10", "ADC in init mid-window", adc_sdto_en, 1'b1);
        adc_pwr = 1'b0;
        #24;
        adc_pwr = 1'b1;
        h = fcnt;
        at_frame(g + 523);
        chk("R10", "old schedule not honoured", adc_ready, 1'b0);
        at_frame(h + 522);
        chk("R10", "restarted count 521", adc_ready, 1'b0);
        at_frame(h + 523);
        chk("R10", "restarted count 522", adc_ready, 1'b1);
    endtask

    task automatic test_dac_bit();
        int g;
        at_frame(fcnt + 1);
        dac_pwr = 1'b0;
        #24;
        chk("R7", "DAC down", dac_ready, 1'b0);
        chk("R7", "DAC idle", dac_idle, 1'b1);
        chk("R7", "ADC unaffected", adc_ready, 1'b1);
        chk("R7", "no register reset", filt_rst, 1'b0);
        @(posedge lrck); #10;
        dac_pwr = 1'b1;
        g = fcnt;
        at_frame(g + 516);
        chk("R7", "DAC re-init 515", dac_ready, 1'b0);
        at_frame(g + 517);
        chk("R7", "DAC re-init 516", dac_ready, 1'b1);
    endtask

    task automatic test_mclk_loss();
        int m;
        at_frame(fcnt + 1);
        mclk_on = 1'b0;
        at_frame(fcnt + 4);
        chk("R9", "ADC down on clock loss", adc_sdto_en, 1'b0);
        chk("R9", "ADC not ready on clock loss", adc_ready, 1'b0);
        chk("R9", "DAC down on clock loss", dac_ready, 1'b0);
        at_frame(fcnt + 1);
        mclk_on = 1'b1;
        m = fcnt;
        at_frame(m + 516);
        chk("R9", "DAC full window 515", dac_ready, 1'b0);
        at_frame(m + 517);
        chk("R9", "DAC full window 516", dac_ready, 1'b1);
        at_frame(m + 522);
        chk("R9", "ADC full window 521", adc_ready, 1'b0);
        at_frame(m + 523);
        chk("R9", "ADC full window 522", adc_ready, 1'b1);
    endtask

    task automatic test_pin_fall();
        int hb;
        at_frame(fcnt + 1);
        hb = hint_n;
        pdn_n = 1'b0;
        #40;
        chki("R8", "hint on pin fall", hint_n, hb + 1);
        chk("R1", "filt_rst on pin fall", filt_rst, 1'b1);
        chk("R1", "ADC down on pin fall", adc_sdto_en, 1'b0);
        chk("R1", "DAC down on pin fall", dac_ready, 1'b0);
    endtask

    initial begin
        #(150000 * 8);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        test_reset();
        test_no_mclk();
        test_startup();
        test_adc_bit_restart();
        test_dac_bit();
        test_mclk_loss();
        test_pin_fall();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule